// File: doc/BRIEF.md
# Radio Packet FIFO with Interrupt Flags

This block holds the byte queue between a host microcontroller and a bit-serial shift register that feeds a radio modem. In receive mode the shift register assembles bits sampled on a bit-clock strobe into bytes and pushes each one into the queue. In transmit mode the queue supplies bytes to the shift register, which sends them out MSB first, one bit per strobe. The host moves bytes through a chip-select plus read/write strobe interface. Each access takes effect on the falling edge of the chip-select.

The block drives level and pulse outputs for the host interrupt logic. These are an active-low not-empty indication, a full level, a one-bit-period byte-received pulse, a sticky overrun flag, a transmit-complete level and a threshold level whose sense depends on the mode. A change of operating mode may flush the queue. Which transitions flush it is set by a fixed table, and one entry of that table depends on whether packet or buffered operation is selected.

Top module: `radio_fifo_irq`

## Requirements
- R1: After reset, count_o is 0, empty_n_o is 0, and full_o, overrun_o, wr_byte_o, tx_done_o and thresh_irq_o are all 0.
- R2: A clock edge that sees host_cs_ni newly low with host_wr_i high stores host_wdata_i in standby or transmit. With host_rd_i high and host_wr_i low, that edge instead moves the oldest byte to host_rdata_o in standby or receive. Bytes leave in the order they were stored.
- R3: full_o is high exactly when count_o equals DEPTH. A push attempted while full, whether from the host or from the receive path, drops the byte and sets overrun_o.
- R4: A cycle with ovr_clr_i high clears overrun_o and empties the queue at that clock edge.
- R5: empty_n_o is 0 exactly when the queue holds no byte. It is refreshed at every edge where host_cs_ni is high or newly low, and it holds its value while host_cs_ni stays low.
- R6: In receive, each bit_tick_i samples rx_bit_i, MSB first. The eighth tick pushes the byte. wr_byte_o is high from that tick until the next tick.
- R7: In transmit, each bit_tick_i drives the next bit on tx_bit_o, MSB first. A new byte is taken from the queue when the previous one has been fully sent.
- R8: tx_done_o is high in transmit when at least one byte has been sent since entering transmit, the queue is empty and the last bit has been driven out.
- R9: thresh_irq_o is high when count_o > thresh_i in standby or receive, and when count_o <= thresh_i in transmit. It is 0 in sleep.
- R10: Mode codes are 0 sleep, 1 standby, 2 receive and 3 transmit. Standby to receive, receive to transmit and transmit to receive flush the queue. Receive to standby and transmit to standby keep it.
- R11: Standby to transmit flushes the queue when packet_mode_i is 0 and keeps it when packet_mode_i is 1.
- R12: Entering sleep from any mode flushes the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode code |
| packet_mode_i | input | 1 | 1 = packet operation, 0 = buffered |
| host_cs_ni | input | 1 | Host data chip-select, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Last byte read by host |
| ovr_clr_i | input | 1 | Write-1 overrun clear, also flushes |
| thresh_i | input | clog2(DEPTH)+1 | Threshold value B |
| bit_tick_i | input | 1 | Bit-period strobe |
| rx_bit_i | input | 1 | Serial receive bit |
| tx_bit_o | output | 1 | Serial transmit bit |
| count_o | output | clog2(DEPTH)+1 | Stored byte count |
| empty_n_o | output | 1 | Not-empty indication |
| full_o | output | 1 | Queue full |
| wr_byte_o | output | 1 | Byte-received pulse |
| overrun_o | output | 1 | Sticky overrun flag |
| tx_done_o | output | 1 | Transmission complete |
| thresh_irq_o | output | 1 | Threshold interrupt level |

## Verification
A pointer or count error shows up at once as a count_o mismatch. A byte stored in the wrong slot shows up on host_rdata_o or tx_bit_o the first time that slot is read. A wrongly flushed or kept queue is visible on count_o one cycle after the mode changes. A swapped threshold sense shows up on thresh_irq_o as soon as the count crosses B. A bad empty_n_o latch shows up only when the receive path pushes while the chip-select is held low, so that case is driven directly.

// File: rtl/radio_fifo_pkg.sv
package radio_fifo_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_RX    = 2'd2,
    MODE_TX    = 2'd3
  } mode_e;

  // flush decision for a mode transition
  function automatic logic flush_on_change(mode_e from_m, mode_e to_m, logic pkt);
    logic f;
    f = 1'b0;
    if (from_m != to_m) begin
      unique case (to_m)
        MODE_SLEEP: f = 1'b1;
        MODE_RX:    f = (from_m == MODE_STBY) || (from_m == MODE_TX);
        MODE_TX:    f = (from_m == MODE_RX) || ((from_m == MODE_STBY) && !pkt);
        default:    f = 1'b0;
      endcase
    end
    return f;
  endfunction
endpackage

// File: rtl/rf_fifo_mem.sv
module rf_fifo_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_nxt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push_ok = push_i && (count != CW'(DEPTH));
  assign pop_ok  = pop_i && (count != '0);

  always_comb begin
    if (flush_i) count_nxt_o = '0;
    else         count_nxt_o = count + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count_nxt_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wr_ptr] <= wdata_i;
  end

  assign rdata_o = mem[rd_ptr];
  assign count_o = count;
endmodule

// File: rtl/rf_serdes.sv
module rf_serdes #(
  parameter int W   = 8,
  localparam int BW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rx_en_i,
  input  logic         tx_en_i,
  input  logic         tx_mode_i,
  input  logic         bit_tick_i,
  input  logic         rx_bit_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         fifo_empty_i,
  output logic         push_o,
  output logic [W-1:0] push_data_o,
  output logic         pop_o,
  output logic         tx_bit_o,
  output logic         wr_byte_o,
  output logic         tx_done_o
);
  logic [BW-1:0] rx_cnt;
  logic [W-2:0]  rx_sr;
  logic [BW-1:0] tx_left;
  logic [W-2:0]  tx_sr;
  logic          tx_started;

  assign push_o      = rx_en_i && bit_tick_i && (rx_cnt == BW'(W - 1));
  assign push_data_o = {rx_sr, rx_bit_i};
  assign pop_o       = tx_en_i && bit_tick_i && (tx_left == '0) && !fifo_empty_i;
  assign tx_done_o   = tx_mode_i && tx_started && (tx_left == '0) && fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cnt    <= '0;
      rx_sr     <= '0;
      wr_byte_o <= 1'b0;
    end else if (!rx_en_i) begin
      rx_cnt    <= '0;
      wr_byte_o <= 1'b0;
    end else if (bit_tick_i) begin
      rx_sr     <= {rx_sr[W-3:0], rx_bit_i};
      rx_cnt    <= push_o ? '0 : rx_cnt + BW'(1);
      wr_byte_o <= push_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_left    <= '0;
      tx_sr      <= '0;
      tx_bit_o   <= 1'b0;
      tx_started <= 1'b0;
    end else if (!tx_en_i) begin
      tx_left    <= '0;
      tx_bit_o   <= 1'b0;
      tx_started <= 1'b0;
    end else if (bit_tick_i) begin
      if (tx_left != '0) begin
        tx_bit_o <= tx_sr[W-2];
        tx_sr    <= {tx_sr[W-3:0], 1'b0};
        tx_left  <= tx_left - BW'(1);
      end else if (pop_o) begin
        tx_bit_o   <= tx_data_i[W-1];
        tx_sr      <= tx_data_i[W-2:0];
        tx_left    <= BW'(W - 1);
        tx_started <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_flag_ctrl.sv
module rf_flag_ctrl
  import radio_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_e         mode_q_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] count_nxt_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          push_i,
  input  logic          ovr_clr_i,
  input  logic          cs_n_i,
  input  logic          cs_fall_i,
  output logic          empty_n_o,
  output logic          full_o,
  output logic          overrun_o,
  output logic          thresh_irq_o
);
  assign full_o = (count_i == CW'(DEPTH));

  always_comb begin
    unique case (mode_q_i)
      MODE_TX:            thresh_irq_o = (count_i <= thresh_i);
      MODE_STBY, MODE_RX: thresh_irq_o = (count_i > thresh_i);
      default:            thresh_irq_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overrun_o <= 1'b0;
      empty_n_o <= 1'b0;
    end else begin
      if (ovr_clr_i)              overrun_o <= 1'b0;
      else if (push_i && full_o)  overrun_o <= 1'b1;
      // frozen while a host access holds the chip-select low
      if (cs_n_i || cs_fall_i) empty_n_o <= (count_nxt_i != '0);
    end
  end
endmodule

// File: rtl/radio_fifo_irq.sv
module radio_fifo_irq
  import radio_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int W    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          packet_mode_i,
  input  logic          host_cs_ni,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [W-1:0]  host_wdata_i,
  output logic [W-1:0]  host_rdata_o,
  input  logic          ovr_clr_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          bit_tick_i,
  input  logic          rx_bit_i,
  output logic          tx_bit_o,
  output logic [CW-1:0] count_o,
  output logic          empty_n_o,
  output logic          full_o,
  output logic          wr_byte_o,
  output logic          overrun_o,
  output logic          tx_done_o,
  output logic          thresh_irq_o
);
  mode_e        mode_q, mode_in;
  logic         mode_chg, flush;
  logic         cs_q, cs_fall;
  logic         host_push, host_pop;
  logic         sd_push, sd_pop;
  logic [W-1:0] sd_push_data, fifo_rdata, push_data;
  logic [CW-1:0] count_nxt;

  assign mode_in  = mode_e'(mode_i);
  assign mode_chg = (mode_in != mode_q);
  assign flush    = ovr_clr_i || (mode_chg && flush_on_change(mode_q, mode_in, packet_mode_i));
  assign cs_fall  = cs_q && !host_cs_ni;

  assign host_push = cs_fall && host_wr_i && !mode_chg &&
                     ((mode_q == MODE_STBY) || (mode_q == MODE_TX));
  assign host_pop  = cs_fall && host_rd_i && !host_wr_i && !mode_chg &&
                     ((mode_q == MODE_STBY) || (mode_q == MODE_RX));
  assign push_data = host_push ? host_wdata_i : sd_push_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_SLEEP;
      cs_q         <= 1'b1;
      host_rdata_o <= '0;
    end else begin
      mode_q <= mode_in;
      cs_q   <= host_cs_ni;
      if (host_pop && (count_o != '0)) host_rdata_o <= fifo_rdata;
    end
  end

  rf_fifo_mem #(.DEPTH(DEPTH), .W(W)) mem_i (
    .clk_i, .rst_ni,
    .flush_i     (flush),
    .push_i      (host_push || sd_push),
    .wdata_i     (push_data),
    .pop_i       (host_pop || sd_pop),
    .rdata_o     (fifo_rdata),
    .count_o     (count_o),
    .count_nxt_o (count_nxt)
  );

  rf_serdes #(.W(W)) serdes_i (
    .clk_i, .rst_ni,
    .rx_en_i      ((mode_q == MODE_RX) && !mode_chg),
    .tx_en_i      ((mode_q == MODE_TX) && !mode_chg),
    .tx_mode_i    (mode_q == MODE_TX),
    .bit_tick_i   (bit_tick_i),
    .rx_bit_i     (rx_bit_i),
    .tx_data_i    (fifo_rdata),
    .fifo_empty_i (count_o == '0),
    .push_o       (sd_push),
    .push_data_o  (sd_push_data),
    .pop_o        (sd_pop),
    .tx_bit_o     (tx_bit_o),
    .wr_byte_o    (wr_byte_o),
    .tx_done_o    (tx_done_o)
  );

  rf_flag_ctrl #(.DEPTH(DEPTH)) flags_i (
    .clk_i, .rst_ni,
    .mode_q_i     (mode_q),
    .count_i      (count_o),
    .count_nxt_i  (count_nxt),
    .thresh_i     (thresh_i),
    .push_i       (host_push || sd_push),
    .ovr_clr_i    (ovr_clr_i),
    .cs_n_i       (host_cs_ni),
    .cs_fall_i    (cs_fall),
    .empty_n_o    (empty_n_o),
    .full_o       (full_o),
    .overrun_o    (overrun_o),
    .thresh_irq_o (thresh_irq_o)
  );
endmodule

// File: rtl/radio_fifo_irq_chk.sv
module radio_fifo_irq_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          ovr_clr_i,
  input logic [CW-1:0] count_o,
  input logic          full_o,
  input logic          overrun_o,
  input logic          wr_byte_o,
  input logic          tx_done_o,
  input logic          thresh_irq_o
);
  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  p_ovr_needs_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(full_o));

  p_ovr_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_clr_i |=> (!overrun_o && count_o == '0));

  p_wr_byte_rx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_byte_o) |-> ($past(mode_i) == 2'd2));

  p_tx_done_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (count_o == '0));

  p_sleep_thresh_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |=> !thresh_irq_o);

  p_sleep_flush_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |=> (count_o == '0));
endmodule

bind radio_fifo_irq radio_fifo_irq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .ovr_clr_i    (ovr_clr_i),
  .count_o      (count_o),
  .full_o       (full_o),
  .overrun_o    (overrun_o),
  .wr_byte_o    (wr_byte_o),
  .tx_done_o    (tx_done_o),
  .thresh_irq_o (thresh_irq_o)
);

// File: tb/radio_fifo_irq_tb_top.sv
module radio_fifo_irq_tb_top;
  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic pkt = 1'b0, cs_n = 1'b1, wr = 1'b0, rd = 1'b0, ovr_clr = 1'b0;
  logic [7:0] wdata = '0;
  logic [CW-1:0] thr = '0;
  logic tick = 1'b0, rx_bit = 1'b0;
  logic [7:0] rdata;
  logic tx_bit, empty_n, full, wr_byte, overrun, tx_done, thr_irq;
  logic [CW-1:0] count;

  int checks = 0, errors = 0;
  int q[$];
  int mode_m = 0;
  bit ovr_m = 0;

  always #4 clk = ~clk;

  radio_fifo_irq #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .packet_mode_i(pkt),
    .host_cs_ni(cs_n), .host_wr_i(wr), .host_rd_i(rd), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .ovr_clr_i(ovr_clr), .thresh_i(thr),
    .bit_tick_i(tick), .rx_bit_i(rx_bit), .tx_bit_o(tx_bit), .count_o(count),
    .empty_n_o(empty_n), .full_o(full), .wr_byte_o(wr_byte),
    .overrun_o(overrun), .tx_done_o(tx_done), .thresh_irq_o(thr_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit m_clears(int f, int t, bit p);
    if (f == t) return 0;
    if (t == 0) return 1;
    if ((f == 1 && t == 2) || (f == 2 && t == 3) || (f == 3 && t == 2)) return 1;
    if (f == 1 && t == 3) return !p;
    return 0;
  endfunction

  function automatic bit m_thr(int m, int n, int b);
    if (m == 3) return n <= b;
    if (m == 1 || m == 2) return n > b;
    return 0;
  endfunction

  task automatic chk_state(input string req);
    chk(count == CW'(q.size()), {req, " count"}, count, q.size());
    chk(full == (q.size() == DEPTH), {req, " full"}, full, q.size() == DEPTH);
    chk(overrun == ovr_m, {req, " overrun"}, overrun, ovr_m);
    chk(thr_irq == m_thr(mode_m, q.size(), thr), {req, " R9 thresh"}, thr_irq,
        m_thr(mode_m, q.size(), thr));
  endtask

  task automatic set_mode(input int m, input string req);
    @(negedge clk);
    mode = 2'(m);
    if (m_clears(mode_m, m, pkt)) q.delete();
    mode_m = m;
    @(negedge clk);
    chk_state(req);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; wr = 1; wdata = d;
    @(negedge clk);
    if (mode_m == 1 || mode_m == 3) begin
      if (q.size() < DEPTH) q.push_back(d); else ovr_m = 1;
    end
    cs_n = 1; wr = 0;
    chk(empty_n == (q.size() != 0), "R5 empty_n after write", empty_n, q.size() != 0);
    chk_state("R2/R3 write");
  endtask

  task automatic host_read();
    int e;
    @(negedge clk);
    cs_n = 0; rd = 1;
    @(negedge clk);
    cs_n = 1; rd = 0;
    if (q.size() != 0 && (mode_m == 1 || mode_m == 2)) begin
      e = q.pop_front();
      chk(rdata == 8'(e), "R2 read data", rdata, e);
    end
    chk(empty_n == (q.size() != 0), "R5 empty_n after read", empty_n, q.size() != 0);
    chk_state("R2 read");
  endtask

  task automatic ovr_clear();
    @(negedge clk);
    ovr_clr = 1;
    @(negedge clk);
    ovr_clr = 0;
    q.delete(); ovr_m = 0;
    chk_state("R4 clear");
  endtask

  task automatic rx_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      rx_bit = d[i]; tick = 1;
      @(negedge clk);
      tick = 0;
      if (i == 7) chk(wr_byte == 0, "R6 pulse ends at next tick", wr_byte, 0);
    end
    if (q.size() < DEPTH) q.push_back(d); else ovr_m = 1;
    chk(wr_byte == 1, "R6 byte pulse", wr_byte, 1);
    chk_state("R6 rx push");
    @(negedge clk);
    chk(wr_byte == 1, "R6 pulse holds for bit period", wr_byte, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e, b;
    logic [15:0] tx_exp;
    void'($urandom(32'h1d5e));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(count == 0 && empty_n == 0 && full == 0 && overrun == 0, "R1 reset", count, 0);
    chk(wr_byte == 0 && tx_done == 0 && thr_irq == 0, "R1 reset irq", tx_done, 0);
    rst_n = 1;
    thr = CW'(3);
    set_mode(1, "R10 sleep->stby");

    // R3 fill to full, overrun, R4 clear
    for (int i = 0; i < DEPTH; i++) host_write(8'(i * 7 + 1));
    chk(full == 1, "R3 full at depth", full, 1);
    host_write(8'hEE);
    chk(overrun == 1, "R3 host overrun", overrun, 1);
    host_read();
    ovr_clear();

    // R10 stby->rx clears, rx push, rx->stby keeps
    host_write(8'h11);
    set_mode(2, "R10 stby->rx");
    rx_byte(8'hA5);
    rx_byte(8'h3C);
    set_mode(1, "R10 rx->stby keep");
    host_read();
    host_read();

    // R5 empty_n held while chip-select low
    set_mode(2, "R10 stby->rx");
    @(negedge clk); cs_n = 0;
    rx_byte(8'h5A);
    chk(empty_n == 0, "R5 held while cs low", empty_n, 0);
    @(negedge clk); cs_n = 1;
    @(negedge clk);
    chk(empty_n == 1, "R5 refresh after cs high", empty_n, 1);

    // R3 overrun from receive path
    for (int i = 1; i < DEPTH; i++) rx_byte(8'(i));
    rx_byte(8'hFF);
    chk(overrun == 1, "R3 rx overrun", overrun, 1);
    set_mode(1, "R10 rx->stby keep full");
    ovr_clear();

    // R11 buffered: stby->tx clears
    pkt = 0;
    host_write(8'h42);
    set_mode(3, "R11 buffered stby->tx");
    set_mode(2, "R10 tx->rx");
    rx_byte(8'h77);
    set_mode(3, "R10 rx->tx");
    set_mode(1, "R10 tx->stby");

    // R11 packet: preload, R7 serial out, R8 done
    pkt = 1;
    host_write(8'hC3);
    host_write(8'h96);
    tx_exp = 16'hC396;
    set_mode(3, "R11 packet stby->tx keep");
    chk(tx_done == 0, "R8 not done before send", tx_done, 0);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      chk(tx_bit == tx_exp[i], "R7 tx bit", tx_bit, tx_exp[i]);
      if (i == 15 || i == 7) void'(q.pop_front());
      if (i == 1) chk(tx_done == 0, "R8 last bit pending", tx_done, 0);
    end
    chk(tx_done == 1, "R8 tx done", tx_done, 1);
    chk_state("R9 tx empty");
    host_write(8'h01);
    chk(tx_done == 0, "R8 done drops on refill", tx_done, 0);
    set_mode(1, "R10 tx->stby keep");
    set_mode(0, "R12 stby->sleep");
    chk(thr_irq == 0, "R9 sleep thresh", thr_irq, 0);

    // random host traffic in standby and transmit
    set_mode(1, "R10 sleep->stby");
    for (int n = 0; n < 400; n++) begin
      e = $urandom_range(0, 99);
      b = $urandom_range(0, DEPTH);
      @(negedge clk); thr = CW'(b);
      if (e < 55) host_write(8'($urandom()));
      else if (e < 93) host_read();
      else if (e < 95) ovr_clear();
      else if (e < 98) set_mode(mode_m == 1 ? 3 : 1, "R10/R11 random mode");
      else begin
        pkt = 1'($urandom());
        set_mode(mode_m == 1 ? 3 : 1, "R11 random pkt");
      end
    end
    set_mode(1, "R10 back to stby");
    set_mode(0, "R12 sleep final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule